// File: doc/BRIEF.md
# Locked Four-Word Burst Bus Master Sequencer

This block is the control sequencer of a bus master on a synchronous, multiplexed address/data backplane that uses a start/acknowledge handshake. A local client hands it one command: a direction, a base address and, for writes, four long words. The block then asks for the bus and waits until it wins arbitration. It opens with a lock attention cycle and moves exactly four 32-bit long words while it keeps ownership. It closes with a null attention cycle, so that every other controller on the bus sees a clear boundary and falls back in step.

The block does not hold the request line across a string of plain transactions, and it adds no idle cycle after an acknowledge. Each data transfer takes two bus clocks when the target answers at once: one address cycle with start asserted, then one data cycle in which the acknowledge is sampled. The request is dropped during the fourth transfer. If an acknowledge returns an error status, the remaining transfers are abandoned, but the null attention cycle is still issued. The one-cycle done pulse then carries the error flag. `clk` is the sampling edge of the bus clock, and all bus inputs are registered on its rising edge.

The command port is a valid/ready stream. `cmd_ready_o` is high only while the block is idle. A command is taken in the cycle where both valid and ready are high, and a held `cmd_valid_i` is otherwise ignored. Read data leaves on a valid-only stream with no back-pressure: each word is presented for exactly one cycle and the consumer must take it then. A bus transfer cannot be stalled without breaking the locked sequence.

Top module: `lbs_burst_master`

## Requirements
- R1: A command is accepted only when `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is high only while idle, so a command offered during a sequence is ignored and starts nothing afterwards.
- R2: After acceptance, `bus_req_o` rises in the next cycle. The block issues nothing on the bus until `bus_grant_i` is sampled high. Acknowledges seen while waiting for the grant have no effect.
- R3: Right after the grant, a lock attention cycle occurs: `bus_start_o` and `bus_ack_o` are both high for one clock, with `bus_mode_o` = 2'b10.
- R4: Each transfer begins with an address cycle. In it `bus_start_o` is high, `bus_ack_o` is low, `bus_ad_oe_o` is high and `bus_mode_o` gives the direction (2'b00 write, 2'b01 read). `bus_ad_o` carries the base address plus 4 times the word index, wrapping at 32 bits. Exactly four transfers are made when no error occurs.
- R5: An acknowledge sampled in a data cycle is followed at once, with no idle cycle, by the next address cycle or by the null attention cycle. With a zero-wait target each transfer therefore takes two clocks.
- R6: `bus_req_o` is high from acceptance through the third transfer and low from the fourth address cycle onward.
- R7: A non-zero `bus_status_i` with an acknowledge aborts the remaining transfers. The next cycle is the null attention cycle.
- R8: After the last transfer, or after an abort, a null attention cycle occurs: start and ack both high, `bus_mode_o` = 2'b11, request low. It is followed by a one-cycle `done_o` pulse, with `done_err_o` high only if an error status was seen.
- R9: For reads, each acknowledge with status 2'b00 delivers `bus_ad_i` on `rd_data_o` with a one-cycle `rd_valid_o` in the next clock. Writes and error acknowledges produce no `rd_valid_o`.
- R10: For writes, word k of `cmd_wdata_i` (bits 32k+31..32k) is driven on `bus_ad_o` with `bus_ad_oe_o` high throughout data cycle k.
- R11: In reset and just after it, `bus_req_o`, `bus_start_o`, `bus_ack_o` and `done_o` are low and `cmd_ready_o` is high. A reset in mid-sequence returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, sampling edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command can be taken |
| cmd_write_i | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr_i | input | 32 | Base byte address |
| cmd_wdata_i | input | 128 | Four write words, word k in bits 32k+31..32k |
| rd_valid_o | output | 1 | Read word valid for this cycle |
| rd_data_o | output | 32 | Read word |
| done_o | output | 1 | Sequence finished (one cycle) |
| done_err_o | output | 1 | Sequence ended on an error status |
| bus_req_o | output | 1 | Bus request |
| bus_grant_i | input | 1 | Arbitration won |
| bus_start_o | output | 1 | Start line (active high here) |
| bus_ack_o | output | 1 | Acknowledge line driven in attention cycles |
| bus_ack_i | input | 1 | Acknowledge from target |
| bus_status_i | input | 2 | Acknowledge status, 2'b00 = success |
| bus_mode_o | output | 2 | Transfer mode: write, read, lock, null |
| bus_ad_o | output | 32 | Address/data out |
| bus_ad_oe_o | output | 1 | Address/data output enable |
| bus_ad_i | input | 32 | Address/data in |

## Verification
The hardest case to reach is an error acknowledge on the last word. There the request has already dropped and the error path and the normal completion path both lead to the same null attention cycle. The only things that tell them apart are `done_err_o` and the missing read pulse. The vector table therefore places the error status on the first, middle and last beats, under different acknowledge latencies and grant delays. A bench-side target model answers each data cycle at the scheduled clock. Two further runs are directed ones. One keeps a second command and stray error acknowledges present while the block waits for the grant, which must not disturb the run. The other resets the block in the middle of a data cycle.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARB, S_LOCK, S_ADDR, S_DATA, S_NULL, S_DONE
  } lbs_state_e;

  localparam logic [1:0] MODE_WR   = 2'b00;
  localparam logic [1:0] MODE_RD   = 2'b01;
  localparam logic [1:0] MODE_LOCK = 2'b10;
  localparam logic [1:0] MODE_NULL = 2'b11;
  localparam logic [1:0] STAT_OK   = 2'b00;
endpackage

// File: rtl/lbs_beat_ctr.sv
module lbs_beat_ctr #(
  parameter int AD_W  = 32,
  parameter int BEATS = 4,
  parameter int STEP  = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AD_W-1:0]  base,
  input  logic             adv,
  output logic [AD_W-1:0]  cur_addr,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      idx      <= '0;
    end else if (load) begin
      cur_addr <= base;
      idx      <= '0;
    end else if (adv) begin
      cur_addr <= cur_addr + AD_W'(STEP);
      idx      <= idx + 1'b1;
    end
  end

  assign last = (idx == IDX_W'(BEATS - 1));
endmodule

// File: rtl/lbs_fsm.sv
module lbs_fsm
  import lbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_fire,
  input  logic       grant,
  input  logic       ack_in,
  input  logic       stat_err,
  input  logic       last,
  output lbs_state_e state,
  output logic       adv,
  output logic       err_q
);
  lbs_state_e nxt;

  always_comb begin
    nxt = state;
    adv = 1'b0;
    unique case (state)
      S_IDLE: if (cmd_fire) nxt = S_ARB;
      S_ARB:  if (grant) nxt = S_LOCK;
      S_LOCK: nxt = S_ADDR;
      S_ADDR: nxt = S_DATA;
      S_DATA: begin
        if (ack_in) begin
          if (stat_err || last) nxt = S_NULL;
          else begin
            nxt = S_ADDR;
            adv = 1'b1;
          end
        end
      end
      S_NULL: nxt = S_DONE;
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      err_q <= 1'b0;
    end else begin
      state <= nxt;
      if (cmd_fire) err_q <= 1'b0;
      else if (state == S_DATA && ack_in && stat_err) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lbs_rd_capture.sv
module lbs_rd_capture #(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [AD_W-1:0] din,
  output logic            vld,
  output logic [AD_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      dout <= '0;
    end else begin
      vld <= cap_en;
      if (cap_en) dout <= din;
    end
  end
endmodule

// File: rtl/lbs_burst_master.sv
module lbs_burst_master
  import lbs_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int BEATS = 4,
  parameter int STEP  = 4,
  localparam int WD_W  = AD_W * BEATS,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic            cmd_write_i,
  input  logic [AD_W-1:0] cmd_addr_i,
  input  logic [WD_W-1:0] cmd_wdata_i,
  output logic            rd_valid_o,
  output logic [AD_W-1:0] rd_data_o,
  output logic            done_o,
  output logic            done_err_o,
  output logic            bus_req_o,
  input  logic            bus_grant_i,
  output logic            bus_start_o,
  output logic            bus_ack_o,
  input  logic            bus_ack_i,
  input  logic [1:0]      bus_status_i,
  output logic [1:0]      bus_mode_o,
  output logic [AD_W-1:0] bus_ad_o,
  output logic            bus_ad_oe_o,
  input  logic [AD_W-1:0] bus_ad_i
);
  lbs_state_e       state;
  logic             cmd_fire, adv, err_q, last, stat_err;
  logic             wr_q;
  logic [WD_W-1:0]  wdata_q;
  logic [AD_W-1:0]  cur_addr;
  logic [IDX_W-1:0] idx;
  logic [AD_W-1:0]  cur_word;

  assign cmd_ready_o = (state == S_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign stat_err    = (bus_status_i != STAT_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cmd_fire) begin
      wr_q    <= cmd_write_i;
      wdata_q <= cmd_wdata_i;
    end
  end

  lbs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .grant(bus_grant_i),
    .ack_in(bus_ack_i), .stat_err(stat_err), .last(last),
    .state(state), .adv(adv), .err_q(err_q)
  );

  lbs_beat_ctr #(.AD_W(AD_W), .BEATS(BEATS), .STEP(STEP)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(cmd_fire), .base(cmd_addr_i), .adv(adv),
    .cur_addr(cur_addr), .idx(idx), .last(last)
  );

  lbs_rd_capture #(.AD_W(AD_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .cap_en((state == S_DATA) && bus_ack_i && !stat_err && !wr_q),
    .din(bus_ad_i), .vld(rd_valid_o), .dout(rd_data_o)
  );

  assign cur_word = wdata_q[idx*AD_W +: AD_W];

  always_comb begin
    bus_req_o   = (state == S_ARB) || (state == S_LOCK) ||
                  (((state == S_ADDR) || (state == S_DATA)) && !last);
    bus_start_o = (state == S_LOCK) || (state == S_ADDR) || (state == S_NULL);
    bus_ack_o   = (state == S_LOCK) || (state == S_NULL);
    bus_ad_oe_o = (state == S_ADDR) || ((state == S_DATA) && wr_q);
    bus_ad_o    = (state == S_ADDR) ? cur_addr :
                  ((state == S_DATA) && wr_q) ? cur_word : '0;
    unique case (state)
      S_LOCK:  bus_mode_o = MODE_LOCK;
      S_NULL:  bus_mode_o = MODE_NULL;
      default: bus_mode_o = wr_q ? MODE_WR : MODE_RD;
    endcase
    done_o     = (state == S_DONE);
    done_err_o = (state == S_DONE) && err_q;
  end
endmodule

// File: rtl/lbs_burst_checker.sv
module lbs_burst_checker
  import lbs_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int BEATS = 4,
  parameter int STEP  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid_i,
  input logic            cmd_ready_o,
  input logic [AD_W-1:0] cmd_addr_i,
  input logic            bus_req_o,
  input logic            bus_grant_i,
  input logic            bus_start_o,
  input logic            bus_ack_o,
  input logic            bus_ack_i,
  input logic [1:0]      bus_status_i,
  input logic [1:0]      bus_mode_o,
  input logic [AD_W-1:0] bus_ad_o,
  input logic            bus_ad_oe_o,
  input logic            done_o,
  input logic            rd_valid_o
);
  logic            lock_attn, null_attn, addr_ph, in_data;
  logic [AD_W-1:0] exp_addr;
  logic [7:0]      beats;

  assign lock_attn = bus_start_o && bus_ack_o && (bus_mode_o == MODE_LOCK);
  assign null_attn = bus_start_o && bus_ack_o && (bus_mode_o == MODE_NULL);
  assign addr_ph   = bus_start_o && !bus_ack_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_addr <= '0;
      beats    <= '0;
      in_data  <= 1'b0;
    end else begin
      if (cmd_valid_i && cmd_ready_o) exp_addr <= cmd_addr_i;
      else if (addr_ph) exp_addr <= exp_addr + AD_W'(STEP);
      if (lock_attn) beats <= '0;
      else if (addr_ph) beats <= beats + 8'd1;
      if (addr_ph) in_data <= 1'b1;
      else if (bus_ack_i) in_data <= 1'b0;
    end
  end

  p_busy_no_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o || bus_start_o) |-> !cmd_ready_o);
  p_lock_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_attn |-> $past(bus_req_o && bus_grant_i));
  p_attn_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start_o && bus_ack_o) |=> !bus_ack_o);
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |-> (bus_ad_o == exp_addr) && bus_ad_oe_o);
  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && bus_ack_i) |=> bus_start_o);
  p_req_drop_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ph && beats == 8'(BEATS - 1)) |-> !bus_req_o);
  p_err_to_null_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && bus_ack_i && bus_status_i != STAT_OK) |=> null_attn);
  p_done_after_null_r8: assert property (@(posedge clk) disable iff (!rst_n)
    null_attn |=> (done_o && !bus_start_o && !bus_req_o));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_rd_from_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(in_data && bus_ack_i && bus_status_i == STAT_OK &&
                         bus_mode_o == MODE_RD));
  p_wr_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && bus_mode_o == MODE_WR) |-> bus_ad_oe_o);
endmodule

bind lbs_burst_master lbs_burst_checker #(.AD_W(AD_W), .BEATS(BEATS), .STEP(STEP))
  u_chk (.*);

// File: tb/tb_lbs_burst_master.sv
module tb_lbs_burst_master;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid_i = 1'b0, cmd_write_i = 1'b0;
  logic [31:0]  cmd_addr_i = '0;
  logic [127:0] cmd_wdata_i = '0;
  logic         cmd_ready_o, rd_valid_o, done_o, done_err_o;
  logic [31:0]  rd_data_o, bus_ad_o;
  logic         bus_req_o, bus_start_o, bus_ack_o, bus_ad_oe_o;
  logic         bus_grant_i = 1'b0, bus_ack_i = 1'b0;
  logic [1:0]   bus_status_i = 2'b00, bus_mode_o;
  logic [31:0]  bus_ad_i = '0;

  int n_cmp = 0, n_bad = 0;
  bit fin = 1'b0;

  always #10 clk = ~clk;

  lbs_burst_master dut (.*);

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  lat;
    logic [2:0]  errb;
    logic [3:0]  gdel;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 32'h0000_1000, 4'd0, 3'd4, 4'd0},
    '{1'b0, 32'h0000_2010, 4'd0, 3'd4, 4'd2},
    '{1'b1, 32'h8000_00F0, 4'd2, 3'd4, 4'd1},
    '{1'b0, 32'hFFFF_FFF4, 4'd1, 3'd4, 4'd0},
    '{1'b1, 32'h0000_3000, 4'd0, 3'd2, 4'd0},
    '{1'b0, 32'h0000_4000, 4'd3, 3'd0, 4'd3},
    '{1'b0, 32'h0000_5000, 4'd0, 3'd3, 4'd0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wword(logic [31:0] a, int b);
    return (a * 32'd3) + (32'h0101_0101 * b) + 32'h5A5A_0000;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(vec_t v, bit hold, bit noise);
    logic [31:0] a;
    cmd_valid_i = 1'b1;
    cmd_write_i = v.wr;
    cmd_addr_i  = v.addr;
    for (int b = 0; b < 4; b++) cmd_wdata_i[b*32 +: 32] = wword(v.addr, b);
    chk("R1 ready idle", {31'd0, cmd_ready_o}, 32'd1);
    tick();
    if (!hold) cmd_valid_i = 1'b0;
    else cmd_addr_i = 32'hDEAD_0000;
    chk("R2 req after accept", {30'd0, bus_req_o, bus_start_o}, 32'd2);
    chk("R1 busy not ready", {31'd0, cmd_ready_o}, 32'd0);
    for (int g = 0; g < v.gdel; g++) begin
      if (noise) begin
        bus_ack_i = 1'b1;
        bus_status_i = 2'b10;
      end
      tick();
      bus_ack_i = 1'b0;
      bus_status_i = 2'b00;
      chk("R2 wait grant", {30'd0, bus_req_o, bus_start_o}, 32'd2);
    end
    bus_grant_i = 1'b1;
    tick();
    bus_grant_i = 1'b0;
    chk("R3 lock attn", {27'd0, bus_start_o, bus_ack_o, bus_mode_o, bus_req_o}, {27'd0, 5'b11101});
    tick();
    for (int b = 0; b < 4; b++) begin
      a = v.addr + 32'(4 * b);
      chk("R4 addr phase", {27'd0, bus_start_o, bus_ack_o, bus_ad_oe_o, bus_mode_o},
          {27'd0, 3'b101, v.wr ? 2'b00 : 2'b01});
      chk("R4 addr value", bus_ad_o, a);
      chk("R6 req level", {31'd0, bus_req_o}, {31'd0, b != 3});
      tick();
      for (int w = 0; w <= v.lat; w++) begin
        chk("R5 data no start", {31'd0, bus_start_o}, 32'd0);
        if (v.wr) begin
          chk("R10 wr oe", {31'd0, bus_ad_oe_o}, 32'd1);
          chk("R10 wr data", bus_ad_o, wword(v.addr, b));
        end
        if (w == v.lat) begin
          bus_ack_i = 1'b1;
          bus_status_i = (b == v.errb) ? 2'b01 : 2'b00;
          bus_ad_i = ~a;
        end
        tick();
      end
      bus_ack_i = 1'b0;
      bus_status_i = 2'b00;
      chk("R9 rd valid", {31'd0, rd_valid_o}, {31'd0, !v.wr && b != v.errb});
      if (!v.wr && b != v.errb) chk("R9 rd data", rd_data_o, ~a);
      if (b == v.errb) break;
    end
    chk((v.errb < 4) ? "R7 null after error" : "R8 null attn",
        {27'd0, bus_start_o, bus_ack_o, bus_mode_o, bus_req_o}, {27'd0, 5'b11110});
    tick();
    chk("R8 done", {30'd0, done_o, done_err_o}, {30'd0, 1'b1, v.errb < 4});
    if (hold) cmd_valid_i = 1'b0;
    tick();
    chk("R8 done one cycle", {31'd0, done_o}, 32'd0);
    chk("R1 idle no restart", {30'd0, cmd_ready_o, bus_req_o}, 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {27'd0, bus_req_o, bus_start_o, bus_ack_o, done_o, cmd_ready_o},
        32'd1);
    rst_n = 1'b1;
    tick();
    chk("R11 after reset", {27'd0, bus_req_o, bus_start_o, bus_ack_o, done_o, cmd_ready_o},
        32'd1);
    foreach (VECS[i]) run(VECS[i], 1'b0, 1'b0);
    // R1 / R2: held command and stray error acks during the grant wait
    run('{1'b0, 32'h0000_6000, 4'd0, 3'd4, 4'd2}, 1'b1, 1'b1);
    // R11: reset in a data cycle
    cmd_valid_i = 1'b1;
    cmd_write_i = 1'b1;
    cmd_addr_i  = 32'h0000_7000;
    tick();
    cmd_valid_i = 1'b0;
    bus_grant_i = 1'b1;
    tick();
    bus_grant_i = 1'b0;
    tick();
    tick();
    chk("R11 in data phase", {30'd0, bus_start_o, bus_ad_oe_o}, 32'd1);
    rst_n = 1'b0;
    tick();
    chk("R11 mid reset", {27'd0, bus_req_o, bus_start_o, bus_ack_o, done_o, cmd_ready_o},
        32'd1);
    rst_n = 1'b1;
    tick();
    chk("R11 idle after reset", {30'd0, cmd_ready_o, bus_ad_oe_o}, 32'd2);
    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule